// File: doc/BRIEF.md
# Serial Control and Status Port for a Hex Half-Bridge Driver

This block is the host-facing serial slave of a six-channel half-bridge driver. A frame opens when the active-low select line falls and closes when it rises. While the frame is open, the block receives a control word on its data input and, at the same time, shifts out a status word that it captured from the protection logic when the frame opened. Both words travel least significant bit first. The block samples input data on falling serial-clock edges and changes its output data on rising edges. The data output is released whenever select is high.

All three serial pins are sampled into a fast system clock. Edges are found there, so no flop is clocked by the serial clock. A received control word is applied only when select rises after exactly one full word of falling clock edges. Any shorter or longer frame leaves the control register as it was. This lets a host read only the temperature warning: it lowers select, reads the first bit, which is on the output before any clock edge, and raises select again. Because the shift path is a plain shift register, the block also works in a daisy chain: bits shifted in come out again one word later.

The applied control word leaves the block as a valid-only stream: `ctrl_valid` pulses for one system cycle together with the new `ctrl_word`. There is no ready signal and no back-pressure. A serial frame cannot be stalled, so the consumer must take every pulse as it comes. The decoded per-switch enables and mode bits are plain level outputs.

Top module: `ssp_port`

## Requirements
- R1: After reset, `ctrl_word` is 0xE000 (the top three bits high, all others low), `ctrl_valid` and `sdo_oe` are low, `run` and `sc_long` are high, and `olc_en` is low.
- R2: `sdo_oe` goes high within a few system cycles after `csn` falls, stays high for the whole frame, and goes low within a few cycles after `csn` rises.
- R3: Status bit 0, the temperature warning captured when `csn` fell, is driven on `sdo` before any serial clock edge occurs.
- R4: Status word layout: bit 0 is the temperature warning, bit 2k+1 is the low-side state of channel k, bit 2k+2 is the high-side state of channel k (k = 0..5), bit 13 is short detected, bit 14 is standby, and bit 15 is supply fail. Status bit i is on `sdo` from the (i)th rising `sck` edge until the next one, so it is valid at the (i)th falling edge (counting from 0).
- R5: The control word is received LSB first, one bit on each falling `sck` edge. When `csn` rises after exactly 16 falling edges, `ctrl_word` takes the received word and `ctrl_valid` pulses high for exactly one cycle.
- R6: A frame with any count of falling edges other than 16, including zero and more than 16, leaves `ctrl_word` unchanged and produces no `ctrl_valid` pulse.
- R7: Control decode: `ls_en[k]` is word bit 2k+1 and `hs_en[k]` is word bit 2k+2. `olc_en` is the inverse of bit 13, because open-load checking is on when that bit is low. `sc_long` is bit 14 and `run` is bit 15.
- R8: Bits received on `sdi` reappear on `sdo` 16 clocks later: in a 32-clock frame, `sdo` bit 16+i equals input bit i.
- R9: The status inputs are captured when `csn` falls. Changes to them later in the frame do not alter the word shifted out.
- R10: `stat_clr` pulses for one cycle, together with `ctrl_valid`, only when an accepted word has bit 0 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `sck` |
| rst_n | input | 1 | Asynchronous active-low reset |
| csn | input | 1 | Frame select, active low |
| sck | input | 1 | Serial clock, idles low |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out (valid when `sdo_oe` is high) |
| sdo_oe | output | 1 | Output enable for the tri-state data pad |
| temp_warn | input | 1 | Temperature prewarning flag |
| sw_ls | input | NCH | Low-side switch state per channel |
| sw_hs | input | NCH | High-side switch state per channel |
| short_det | input | 1 | Short-circuit shutdown flag |
| standby | input | 1 | Standby indicator |
| supply_fail | input | 1 | Supply undervoltage flag |
| ctrl_word | output | 2*NCH+4 | Applied control register |
| ctrl_valid | output | 1 | One-cycle pulse when `ctrl_word` is updated |
| stat_clr | output | 1 | One-cycle status-clear request |
| ls_en | output | NCH | Low-side enables |
| hs_en | output | NCH | High-side enables |
| olc_en | output | 1 | Open-load checking enabled |
| sc_long | output | 1 | Long short-circuit delay selected |
| run | output | 1 | Software run (high) / standby (low) |

## Verification
The bench uses the default six channels, which gives the 16-bit word, and a two-stage synchronizer. With a word this short, the bench can walk a single set bit through every status position and every control position, checking the full shifted word and every decoded output each time. It also sweeps the frame length from zero to twenty clocks, which covers the exact-count acceptance rule and takes the edge counter into saturation. A 32-clock frame shows the one-word daisy-chain delay.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef struct packed {
    logic cs_fall;
    logic cs_rise;
    logic sck_rise;
    logic sck_fall;
  } ssp_evt_t;

  function automatic int unsigned ssp_word_w(input int unsigned nch);
    return 2 * nch + 4;
  endfunction
endpackage

// File: rtl/ssp_sync.sv
module ssp_sync #(
  parameter int unsigned W = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/ssp_frame.sv
module ssp_frame
  import ssp_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     csn_s,
  input  logic     sck_s,
  output ssp_evt_t evt,
  output logic     accept
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] SAT  = CNT_W'(WORD_W + 1);

  logic             prev_csn, prev_sck;
  logic [CNT_W-1:0] cnt;
  logic             in_frame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_csn <= 1'b1;
      prev_sck <= 1'b0;
    end else begin
      prev_csn <= csn_s;
      prev_sck <= sck_s;
    end
  end

  assign in_frame     = !csn_s && !prev_csn;
  assign evt.cs_fall  = prev_csn && !csn_s;
  assign evt.cs_rise  = !prev_csn && csn_s;
  assign evt.sck_rise = in_frame && sck_s && !prev_sck;
  assign evt.sck_fall = in_frame && !sck_s && prev_sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (evt.cs_fall) begin
      cnt <= '0;
    end else if (evt.sck_fall && cnt != SAT) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign accept = evt.cs_rise && (cnt == FULL);

  AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= SAT); // R6
  AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({evt.cs_fall, evt.cs_rise, evt.sck_rise, evt.sck_fall}) <= 1); // R5
endmodule

// File: rtl/ssp_shift.sv
module ssp_shift
  import ssp_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ssp_evt_t          evt,
  input  logic              sdi_s,
  input  logic [WORD_W-1:0] snap,
  output logic [WORD_W-1:0] rx_word,
  output logic              sdo_q,
  output logic              oe_q
);
  logic [WORD_W-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr <= '0;
    end else if (evt.cs_fall) begin
      sr <= snap;
    end else if (evt.sck_fall) begin
      sr <= {sdi_s, sr[WORD_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdo_q <= 1'b0;
    end else if (evt.cs_fall) begin
      sdo_q <= snap[0];
    end else if (evt.sck_rise) begin
      sdo_q <= sr[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q <= 1'b0;
    end else if (evt.cs_fall) begin
      oe_q <= 1'b1;
    end else if (evt.cs_rise) begin
      oe_q <= 1'b0;
    end
  end

  assign rx_word = sr;

  AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    evt.cs_rise |=> !oe_q); // R2
  AST_SDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt.sck_rise && !evt.cs_fall) |=> $stable(sdo_q)); // R4
  AST_SNAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt.cs_fall && !evt.sck_fall) |=> $stable(sr)); // R9
endmodule

// File: rtl/ssp_ctrl.sv
module ssp_ctrl #(
  parameter int unsigned NCH = 6,
  parameter int unsigned WORD_W = 2 * NCH + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [WORD_W-1:0] rx_word,
  output logic [WORD_W-1:0] ctrl_q,
  output logic              ctrl_valid,
  output logic              stat_clr,
  output logic [NCH-1:0]    ls_en,
  output logic [NCH-1:0]    hs_en,
  output logic              olc_en,
  output logic              sc_long,
  output logic              run
);
  localparam int unsigned OLC_BIT = 2 * NCH + 1;
  localparam int unsigned SCT_BIT = 2 * NCH + 2;
  localparam int unsigned RUN_BIT = 2 * NCH + 3;
  localparam logic [WORD_W-1:0] CTRL_RST = {3'b111, {(WORD_W-3){1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= CTRL_RST;
      ctrl_valid <= 1'b0;
      stat_clr   <= 1'b0;
    end else begin
      ctrl_valid <= accept;
      stat_clr   <= accept && rx_word[0];
      if (accept) ctrl_q <= rx_word;
    end
  end

  for (genvar k = 0; k < NCH; k++) begin : g_chan
    assign ls_en[k] = ctrl_q[2*k+1];
    assign hs_en[k] = ctrl_q[2*k+2];
  end

  assign olc_en  = !ctrl_q[OLC_BIT];
  assign sc_long = ctrl_q[SCT_BIT];
  assign run     = ctrl_q[RUN_BIT];

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_valid |-> $stable(ctrl_q)); // R6
  AST_VALID_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_valid |=> !ctrl_valid); // R5
  AST_CLR_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    stat_clr |-> (ctrl_valid && ctrl_q[0])); // R10
endmodule

// File: rtl/ssp_port.sv
module ssp_port
  import ssp_pkg::*;
#(
  parameter int unsigned NCH = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   csn,
  input  logic                   sck,
  input  logic                   sdi,
  output logic                   sdo,
  output logic                   sdo_oe,
  input  logic                   temp_warn,
  input  logic [NCH-1:0]         sw_ls,
  input  logic [NCH-1:0]         sw_hs,
  input  logic                   short_det,
  input  logic                   standby,
  input  logic                   supply_fail,
  output logic [2*NCH+3:0]       ctrl_word,
  output logic                   ctrl_valid,
  output logic                   stat_clr,
  output logic [NCH-1:0]         ls_en,
  output logic [NCH-1:0]         hs_en,
  output logic                   olc_en,
  output logic                   sc_long,
  output logic                   run
);
  localparam int unsigned WORD_W = ssp_word_w(NCH);

  logic [2:0]        pins_s;
  logic              csn_s, sck_s, sdi_s;
  ssp_evt_t          evt;
  logic              accept;
  logic [WORD_W-1:0] snap, rx_word;

  ssp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sdi, sck, csn}), .q(pins_s)
  );
  assign csn_s = pins_s[0];
  assign sck_s = pins_s[1];
  assign sdi_s = pins_s[2];

  assign snap[0] = temp_warn;
  for (genvar k = 0; k < NCH; k++) begin : g_stat
    assign snap[2*k+1] = sw_ls[k];
    assign snap[2*k+2] = sw_hs[k];
  end
  assign snap[2*NCH+1] = short_det;
  assign snap[2*NCH+2] = standby;
  assign snap[2*NCH+3] = supply_fail;

  ssp_frame #(.WORD_W(WORD_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .csn_s(csn_s), .sck_s(sck_s),
    .evt(evt), .accept(accept)
  );

  ssp_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .evt(evt), .sdi_s(sdi_s), .snap(snap),
    .rx_word(rx_word), .sdo_q(sdo), .oe_q(sdo_oe)
  );

  ssp_ctrl #(.NCH(NCH), .WORD_W(WORD_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .accept(accept), .rx_word(rx_word),
    .ctrl_q(ctrl_word), .ctrl_valid(ctrl_valid), .stat_clr(stat_clr),
    .ls_en(ls_en), .hs_en(hs_en), .olc_en(olc_en), .sc_long(sc_long), .run(run)
  );

  AST_WARN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> (sdo == $past(temp_warn))); // R3
  AST_APPLY_ON_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_valid |-> !sdo_oe); // R5
endmodule

// File: tb/tb_ssp_port.sv
module tb_ssp_port;
  localparam int CLK_P = 10;
  localparam int HALF  = 6;
  localparam int NCH   = 6;

  logic clk = 0, rst_n = 0;
  logic csn = 1, sck = 0, sdi = 0;
  logic sdo, sdo_oe;
  logic [15:0] stat_v = '0;
  logic temp_warn, short_det, standby, supply_fail;
  logic [NCH-1:0] sw_ls, sw_hs, ls_en, hs_en;
  logic [15:0] ctrl_word;
  logic ctrl_valid, stat_clr, olc_en, sc_long, run;

  int total = 0, bad = 0, vcnt = 0, ccnt = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  always_comb begin
    temp_warn = stat_v[0];
    for (int k = 0; k < NCH; k++) begin
      sw_ls[k] = stat_v[2*k+1];
      sw_hs[k] = stat_v[2*k+2];
    end
    short_det   = stat_v[13];
    standby     = stat_v[14];
    supply_fail = stat_v[15];
  end

  ssp_port dut (
    .clk(clk), .rst_n(rst_n), .csn(csn), .sck(sck), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .temp_warn(temp_warn), .sw_ls(sw_ls),
    .sw_hs(sw_hs), .short_det(short_det), .standby(standby),
    .supply_fail(supply_fail), .ctrl_word(ctrl_word), .ctrl_valid(ctrl_valid),
    .stat_clr(stat_clr), .ls_en(ls_en), .hs_en(hs_en), .olc_en(olc_en),
    .sc_long(sc_long), .run(run)
  );

  always @(posedge clk) begin
    if (rst_n && ctrl_valid) vcnt++;
    if (rst_n && stat_clr) ccnt++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic [31:0] tx, input int n, input bit do_mid,
                       input logic [15:0] mid_stat, output logic [31:0] rx,
                       output logic lead, output logic oe_in);
    rx = '0;
    csn = 0;
    wait_clk(6);
    lead  = sdo;
    oe_in = sdo_oe;
    for (int i = 0; i < n; i++) begin
      sdi = tx[i % 32];
      wait_clk(2);
      sck = 1;
      wait_clk(HALF);
      if (i < 32) rx[i] = sdo;
      if (do_mid && i == 1) stat_v = mid_stat;
      sck = 0;
      wait_clk(HALF);
      oe_in = oe_in & sdo_oe;
    end
    wait_clk(2);
    csn = 1;
    wait_clk(6);
  endtask

  task automatic chk_decode(input logic [15:0] w);
    logic [NCH-1:0] el, eh;
    for (int k = 0; k < NCH; k++) begin
      el[k] = w[2*k+1];
      eh[k] = w[2*k+2];
    end
    chk(ls_en == el, "R7 ls_en", 32'(ls_en), 32'(el));
    chk(hs_en == eh, "R7 hs_en", 32'(hs_en), 32'(eh));
    chk(olc_en == !w[13], "R7 olc_en", 32'(olc_en), 32'(!w[13]));
    chk(sc_long == w[14], "R7 sc_long", 32'(sc_long), 32'(w[14]));
    chk(run == w[15], "R7 run", 32'(run), 32'(w[15]));
  endtask

  initial begin
    logic [31:0] rx;
    logic lead, oe_in;
    logic [15:0] cur;
    int v0, c0;

    wait_clk(5);
    chk(ctrl_word == 16'hE000, "R1 ctrl reset", 32'(ctrl_word), 32'hE000);
    chk(sdo_oe == 0, "R1 oe reset", 32'(sdo_oe), 0);
    chk(ctrl_valid == 0, "R1 valid reset", 32'(ctrl_valid), 0);
    rst_n = 1;
    wait_clk(3);
    chk(ctrl_word == 16'hE000, "R1 ctrl after release", 32'(ctrl_word), 32'hE000);
    chk(run && sc_long && !olc_en, "R1 decoded reset", {29'b0, run, sc_long, olc_en}, 32'b110);

    // status sweep: all-zero word and each bit alone
    for (int b = -1; b < 16; b++) begin
      logic [15:0] tx;
      stat_v = (b < 0) ? 16'h0 : (16'h1 << b);
      tx = 16'h1000 + 16'(b + 1) * 16'h0111;
      v0 = vcnt;
      frame({16'h0, tx}, 16, 0, 16'h0, rx, lead, oe_in);
      chk(oe_in == 1, "R2 oe during frame", 32'(oe_in), 1);
      chk(sdo_oe == 0, "R2 oe after frame", 32'(sdo_oe), 0);
      chk(lead == stat_v[0], "R3 lead bit", 32'(lead), 32'(stat_v[0]));
      chk(rx[15:0] == stat_v, "R4 status word", rx, 32'(stat_v));
      chk(ctrl_word == tx, "R5 ctrl applied", 32'(ctrl_word), 32'(tx));
      chk(vcnt == v0 + 1, "R5 one valid pulse", 32'(vcnt - v0), 1);
    end

    // control sweep: each bit alone
    stat_v = 16'h0;
    for (int b = 0; b < 16; b++) begin
      logic [15:0] tx;
      tx = 16'h1 << b;
      v0 = vcnt;
      c0 = ccnt;
      frame({16'h0, tx}, 16, 0, 16'h0, rx, lead, oe_in);
      chk(ctrl_word == tx, "R5 ctrl one-hot", 32'(ctrl_word), 32'(tx));
      chk(vcnt == v0 + 1, "R5 valid one-hot", 32'(vcnt - v0), 1);
      chk_decode(tx);
      chk(ccnt == c0 + ((b == 0) ? 1 : 0), "R10 clear pulse", 32'(ccnt - c0),
          (b == 0) ? 1 : 0);
    end

    // frame length sweep
    cur = 16'h6A52;
    frame({16'h0, cur}, 16, 0, 16'h0, rx, lead, oe_in);
    for (int n = 0; n <= 20; n++) begin
      if (n != 16) begin
        v0 = vcnt;
        frame({16'h0, ~cur}, n, 0, 16'h0, rx, lead, oe_in);
        chk(ctrl_word == cur, "R6 aborted frame ignored", 32'(ctrl_word), 32'(cur));
        chk(vcnt == v0, "R6 no valid on abort", 32'(vcnt - v0), 0);
      end
    end

    // daisy chain: 32 clocks
    stat_v = 16'h3C96;
    v0 = vcnt;
    frame({16'hFFFF, 16'hA5C3}, 32, 0, 16'h0, rx, lead, oe_in);
    chk(rx[31:16] == 16'hA5C3, "R8 pass-through", 32'(rx[31:16]), 32'hA5C3);
    chk(rx[15:0] == 16'h3C96, "R4 status in long frame", 32'(rx[15:0]), 32'h3C96);
    chk(ctrl_word == cur && vcnt == v0, "R6 long frame ignored", 32'(ctrl_word), 32'(cur));

    // snapshot: inputs change during frame
    stat_v = 16'h1235;
    frame({16'h0, 16'h8002}, 16, 1, 16'hEDCA, rx, lead, oe_in);
    chk(rx[15:0] == 16'h1235, "R9 snapshot held", rx, 32'h1235);
    chk(ctrl_word == 16'h8002, "R5 ctrl with snapshot", 32'(ctrl_word), 32'h8002);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule